// File: doc/BRIEF.md
# One-Wire ROM Search Step Sequencer

This block carries out a single branch step of the ROM-search walk on a one-wire bus. A start strobe, together with a preferred branch bit, begins a step. The sequencer asks an external bit-slot engine for two read slots. The first slot returns the address bit that the devices on the bus share, and the second slot returns the complement of that bit. The sequencer then picks the branch by a fixed rule. Unless no device answered, it asks the engine for one write slot that drives the chosen branch bit back onto the bus.

Each slot uses a request/done handshake. The block holds the request high until the engine pulses done, and a read slot also returns one data bit. At the end of the step the block pulses a done strobe and presents a 3-bit code: bit 0 is the address bit, bit 1 is the complement bit and bit 2 is the chosen branch. A watchdog counter limits how long the block waits on each slot, so a stalled engine cannot hang the search. The outer search bookkeeping lives elsewhere.

Top module: `ow_triplet_seq`

## Requirements
- R1: While `rst` is high and after it is released, `slot_req_o`, `step_done_o` and `step_err_o` are 0 and `step_code_o` reads 3'b011.
- R2: A step issues two read slots (`slot_rd_o`=1). The first supplies the address bit and the second supplies the complement bit, and both come before any write slot.
- R3: A slot request rises one cycle after the slot state is entered. It stays high until `slot_done_i` is seen and drops in the following cycle.
- R4: When both read bits are 1, the code is 3'b011 and no write slot is issued.
- R5: When both read bits are 0, the branch is the preferred bit: code 3'b100 for preference 1, 3'b000 for preference 0.
- R6: When exactly one read bit is 1, the branch equals the address bit: code 3'b101 if the address bit is 1, 3'b010 if the complement bit is 1.
- R7: Apart from the no-device case, one write slot (`slot_rd_o`=0) drives the branch bit on `slot_wbit_o` before the step completes.
- R8: Code layout: bit 0 = address bit, bit 1 = complement bit, bit 2 = branch bit.
- R9: `step_done_o` is a one-cycle pulse. `step_code_o` changes only in the cycle that `step_done_o` is high and holds its value until then.
- R10: A start strobe that arrives while a step is in progress has no effect. No extra slot and no extra done pulse follow it.
- R11: If a request stays high for `TMO_CYCLES` cycles without done, the step aborts with code 3'b011, and `step_err_o` is high only in the done cycle. A done on the last of those cycles is still accepted.
- R12: The preferred bit is sampled with the start strobe. Later changes of `pref_dir_i` do not affect that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a step when the block is idle |
| pref_dir_i | input | 1 | Preferred branch bit used when the read bits conflict |
| slot_req_o | output | 1 | Slot request to the bit-slot engine |
| slot_rd_o | output | 1 | 1 = read slot, 0 = write slot |
| slot_wbit_o | output | 1 | Bit to drive in a write slot |
| slot_done_i | input | 1 | Engine finished the requested slot |
| slot_rbit_i | input | 1 | Bit sampled in a read slot, valid with done |
| step_done_o | output | 1 | One-cycle step completion pulse |
| step_code_o | output | 3 | Step result code |
| step_err_o | output | 1 | Slot timeout abort, high with done |

## Verification
The hardest cases to reach from the ports are the timeout edges: a done that arrives on the very last allowed request cycle, and a stall that happens in the write slot after both reads have succeeded. The bench uses a behavioural slot engine whose response latency can be set per step, and whose read and write responses can be disabled separately. This lets it place done exactly on cycle `TMO_CYCLES`-1 and starve only the write slot. It also counts the cycles in which the request is high, to confirm the abort point, and it pulses a second start in the middle of a step.

// File: rtl/ow_triplet_pkg.sv
package ow_triplet_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ID,
    ST_RD_CMP,
    ST_DECIDE,
    ST_WR_DIR,
    ST_DONE
  } trip_state_t;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_NODEV = 3'b011;
endpackage

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
  parameter int TMO_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic done,
  output logic expire
);
  localparam int CW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // the abort fires in the TMO_CYCLES-th request cycle if done is still missing
  assign expire = req && !done && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!req || done || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_cnt_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !req |=> cnt_q == '0);
endmodule

// File: rtl/ow_branch_pick.sv
module ow_branch_pick
  import ow_triplet_pkg::*;
(
  input  logic              id_bit,
  input  logic              cmp_bit,
  input  logic              pref,
  output logic              dir,
  output logic              no_dev,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    no_dev = id_bit && cmp_bit;
    if (no_dev) begin
      dir = 1'b0;
    end else if (!id_bit && !cmp_bit) begin
      dir = pref;
    end else begin
      dir = id_bit;
    end
    code = {dir, cmp_bit, id_bit};
  end
endmodule

// File: rtl/ow_triplet_seq.sv
module ow_triplet_seq
  import ow_triplet_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              pref_dir_i,
  output logic              slot_req_o,
  output logic              slot_rd_o,
  output logic              slot_wbit_o,
  input  logic              slot_done_i,
  input  logic              slot_rbit_i,
  output logic              step_done_o,
  output logic [CODE_W-1:0] step_code_o,
  output logic              step_err_o
);
  trip_state_t       state_q;
  logic              req_q, rd_q, wbit_q;
  logic              id_q, cmp_q, pref_q;
  logic [CODE_W-1:0] code_q;
  logic              err_q;
  logic              expire;
  logic              pick_dir, pick_nodev;
  logic [CODE_W-1:0] pick_code;
  logic              slot_ack;

  ow_slot_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .req    (req_q),
    .done   (slot_done_i),
    .expire (expire)
  );

  ow_branch_pick u_pick (
    .id_bit  (id_q),
    .cmp_bit (cmp_q),
    .pref    (pref_q),
    .dir     (pick_dir),
    .no_dev  (pick_nodev),
    .code    (pick_code)
  );

  assign slot_ack = req_q && slot_done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      rd_q    <= 1'b1;
      wbit_q  <= 1'b0;
      id_q    <= 1'b0;
      cmp_q   <= 1'b0;
      pref_q  <= 1'b0;
      code_q  <= CODE_NODEV;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          err_q <= 1'b0;
          if (start_i) begin
            pref_q  <= pref_dir_i;
            rd_q    <= 1'b1;
            state_q <= ST_RD_ID;
          end
        end
        ST_RD_ID, ST_RD_CMP: begin
          if (!req_q) begin
            req_q <= 1'b1;
          end else if (slot_ack) begin
            req_q <= 1'b0;
            if (state_q == ST_RD_ID) begin
              id_q    <= slot_rbit_i;
              state_q <= ST_RD_CMP;
            end else begin
              cmp_q   <= slot_rbit_i;
              state_q <= ST_DECIDE;
            end
          end else if (expire) begin
            req_q   <= 1'b0;
            code_q  <= CODE_NODEV;
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_DECIDE: begin
          if (pick_nodev) begin
            code_q  <= pick_code;
            state_q <= ST_DONE;
          end else begin
            wbit_q  <= pick_dir;
            rd_q    <= 1'b0;
            state_q <= ST_WR_DIR;
          end
        end
        ST_WR_DIR: begin
          if (!req_q) begin
            req_q <= 1'b1;
          end else if (slot_ack) begin
            req_q   <= 1'b0;
            rd_q    <= 1'b1;
            code_q  <= pick_code;
            state_q <= ST_DONE;
          end else if (expire) begin
            req_q   <= 1'b0;
            rd_q    <= 1'b1;
            code_q  <= CODE_NODEV;
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          err_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign slot_req_o  = req_q;
  assign slot_rd_o   = rd_q;
  assign slot_wbit_o = wbit_q;
  assign step_done_o = (state_q == ST_DONE);
  assign step_code_o = code_q;
  assign step_err_o  = err_q;

  p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
    (slot_req_o && !slot_done_i && !expire) |=> slot_req_o);
  p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (slot_req_o && slot_done_i) |=> !slot_req_o);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    step_done_o |=> !step_done_o);
  p_code_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !step_done_o |-> $stable(step_code_o));
  p_err_code_r11: assert property (@(posedge clk) disable iff (rst)
    step_err_o |-> (step_done_o && step_code_o == CODE_NODEV));
  p_nodev_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (slot_req_o && !slot_rd_o) |-> !(id_q && cmp_q));
endmodule

// File: tb/ow_triplet_seq_bench.sv
`timescale 1ns/1ps
module ow_triplet_seq_bench;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic pref_dir_i = 1'b0;
  logic slot_req_o, slot_rd_o, slot_wbit_o;
  logic slot_done_i = 1'b0;
  logic slot_rbit_i = 1'b0;
  logic step_done_o, step_err_o;
  logic [2:0] step_code_o;

  int n_chk = 0;
  int n_bad = 0;

  // slot engine model controls and records
  int   eng_lat = 0;
  logic eng_rd_en = 1'b1;
  logic eng_wr_en = 1'b1;
  logic eng_id = 1'b0;
  logic eng_cmp = 1'b0;
  int   n_rd = 0;
  int   n_wr = 0;
  int   req_cyc = 0;
  logic last_wbit = 1'b0;
  logic bad_order = 1'b0;
  int   wcnt = 0;

  always #4 clk = ~clk;

  ow_triplet_seq #(.TMO_CYCLES(TMO)) u_ow_triplet_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .pref_dir_i  (pref_dir_i),
    .slot_req_o  (slot_req_o),
    .slot_rd_o   (slot_rd_o),
    .slot_wbit_o (slot_wbit_o),
    .slot_done_i (slot_done_i),
    .slot_rbit_i (slot_rbit_i),
    .step_done_o (step_done_o),
    .step_code_o (step_code_o),
    .step_err_o  (step_err_o)
  );

  initial begin
    forever begin
      @(negedge clk);
      slot_done_i = 1'b0;
      if (slot_req_o) req_cyc++;
      if (slot_req_o && (slot_rd_o ? eng_rd_en : eng_wr_en)) begin
        if (wcnt == eng_lat) begin
          slot_done_i = 1'b1;
          wcnt = 0;
          if (slot_rd_o) begin
            slot_rbit_i = (n_rd == 0) ? eng_id : eng_cmp;
            if (n_wr > 0) bad_order = 1'b1;
            n_rd++;
          end else begin
            last_wbit = slot_wbit_o;
            n_wr++;
          end
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_eng();
    n_rd = 0; n_wr = 0; req_cyc = 0; bad_order = 1'b0; last_wbit = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (step_done_o) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // start a step; the preference is flipped right after start (R12)
  task automatic launch(input logic id, input logic cmp, input logic pref, input int lat);
    @(negedge clk);
    eng_id = id; eng_cmp = cmp; eng_lat = lat;
    clear_eng();
    start_i = 1'b1; pref_dir_i = pref;
    @(negedge clk);
    start_i = 1'b0; pref_dir_i = ~pref;
  endtask

  // id, cmp, pref, latency[3:0], code[2:0], write expected, write bit
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 4'd0, 3'b000, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b1, 4'd2, 3'b100, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b0, 4'd1, 3'b010, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 4'd3, 3'b010, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 4'd0, 3'b101, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b1, 4'd4, 3'b101, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b0, 4'd1, 3'b011, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 4'd0, 3'b011, 1'b0, 1'b0}
  };

  initial begin
    bit seen;
    logic [2:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!slot_req_o && !step_done_o && !step_err_o, "R1 outputs in reset", slot_req_o, 0);
    chk(step_code_o == 3'b011, "R1 code in reset", step_code_o, 3);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!slot_req_o && !step_done_o && step_code_o == 3'b011, "R1 after release", step_code_o, 3);

    // table walk: R2 R4 R5 R6 R7 R8 R9 R12
    for (int v = 0; v < 8; v++) begin
      logic [11:0] e;
      e = VEC[v];
      launch(e[11], e[10], e[9], int'(e[8:5]));
      wait_done(seen);
      chk(seen, "R9 step done seen", seen, 1);
      chk(step_code_o == e[4:2], "R5/R6/R8/R12 code", step_code_o, e[4:2]);
      chk(!step_err_o, "R11 no error", step_err_o, 0);
      chk(n_rd == 2 && !bad_order, "R2 two reads before write", n_rd, 2);
      chk(n_wr == int'(e[1]), "R4/R7 write count", n_wr, e[1]);
      if (e[1]) chk(last_wbit == e[0], "R7 written bit", last_wbit, e[0]);
      held = step_code_o;
      @(negedge clk);
      chk(!step_done_o, "R9 done one cycle", step_done_o, 0);
      repeat (3) @(negedge clk);
      chk(step_code_o == held && !slot_req_o, "R9 code held", step_code_o, held);
    end

    // R3 request held across long latency
    launch(1'b0, 1'b1, 1'b0, 9);
    wait_done(seen);
    chk(req_cyc == 30, "R3 request cycles with latency 9", req_cyc, 30);

    // R10 start while busy
    launch(1'b1, 1'b0, 1'b0, 4);
    repeat (5) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(seen);
    chk(step_code_o == 3'b101, "R10 code", step_code_o, 5);
    clear_eng();
    repeat (12) @(negedge clk);
    chk(req_cyc == 0 && n_rd == 0 && !step_done_o, "R10 no extra step", req_cyc, 0);

    // R11 done on last allowed cycle accepted
    launch(1'b0, 1'b0, 1'b1, TMO - 1);
    wait_done(seen);
    chk(step_code_o == 3'b100 && !step_err_o, "R11 boundary accepted", step_code_o, 4);

    // R11 read slot stalls
    eng_rd_en = 1'b0;
    launch(1'b0, 1'b0, 1'b0, 0);
    wait_done(seen);
    chk(step_err_o && step_code_o == 3'b011, "R11 read abort", step_code_o, 3);
    chk(req_cyc == TMO, "R11 abort point", req_cyc, TMO);
    @(negedge clk);
    chk(!step_err_o && !slot_req_o, "R11 error one cycle", step_err_o, 0);
    eng_rd_en = 1'b1;

    // R11 write slot stalls
    eng_wr_en = 1'b0;
    launch(1'b1, 1'b0, 1'b0, 0);
    wait_done(seen);
    chk(step_err_o && step_code_o == 3'b011 && n_rd == 2, "R11 write abort", step_code_o, 3);
    eng_wr_en = 1'b1;

    // recovery after abort
    launch(1'b0, 1'b0, 1'b0, 1);
    wait_done(seen);
    chk(step_code_o == 3'b000 && !step_err_o, "R5 after abort", step_code_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule